// File: doc/BRIEF.md
# Ethernet MAC Pause and Backpressure Timer

This block decides when an Ethernet MAC should emit flow-control traffic and for how long. It reads one 32-bit configuration word made of two 16-bit fields: a repeat interval in the low half and a pause quantity in the high half. A duplex select input picks one of two behaviours. A flow-control enable input starts a session on its rising edge, and a tick input sets the rate at which the one internal counter advances. The tick lets the interval be scaled to slot times or any other unit.

With full duplex selected, the block offers PAUSE requests to the transmitter over a valid/ready handshake. Each request carries the pause quantity the frame builder must insert. After the transmitter takes a request, the counter runs up to the repeat interval and then a new request is raised. When the enable drops, the block sends one last request carrying a quantity of zero, which releases the link partner.

With half duplex selected, the block drives a backpressure level for a number of ticks equal to the pause quantity. A 32-bit status output always shows the live counter value.

Handshake rules: a request is taken on a rising clock edge where `pause_valid` and `pause_ready` are both high. While `pause_valid` is high and `pause_ready` is low, the request stays up and its `pause_time` does not change. The transmitter may hold `pause_ready` low for as long as it needs. The block never withdraws a request that has not been taken.

Top module: `flowctl_pause_timer`

## Requirements
- R1: During and right after reset, `pause_valid` and `backpressure` are low and `status_word` is zero.
- R2: With `full_duplex`=1, a rising edge of `fc_enable` seen in idle raises `pause_valid` in the next cycle, and `pause_time` then equals cfg_word[31:16].
- R3: Once raised, `pause_valid` stays high and `pause_time` stays unchanged until a cycle in which `pause_ready` is high.
- R4: When a regular request is taken, the counter restarts at 0 and then gains 1 per cycle with `tick` high. The cycle after it equals cfg_word[15:0] (M, nonzero), a new request is raised, so with `tick` held high `pause_valid` is low for exactly M+1 cycles.
- R5: While `tick` is low, and no start or handshake occurs, the counter and therefore `status_word` hold their value, and no new request appears.
- R6: With cfg_word[15:0]=0, a full-duplex session issues its first request only once and never repeats it while `fc_enable` stays high.
- R7: In full duplex, once `fc_enable` is low, no further regular request is raised. A request still pending is completed as it is. Then exactly one request with `pause_time`=0 is issued, after which `pause_valid` stays low.
- R8: With `full_duplex`=0, a rising edge of `fc_enable` asserts `backpressure` for exactly P cycles with `tick` high, where P=cfg_word[31:16]. `pause_valid` stays low throughout.
- R9: In half duplex with P=0, `backpressure` is never asserted.
- R10: In half duplex, dropping `fc_enable` deasserts `backpressure` in the next cycle.
- R11: `status_word[15:0]` is the live counter value and `status_word[31:16]` reads 0.
- R12: Only a rising edge of `fc_enable` starts a session. A level held high after a session ends starts nothing. The duplex mode is sampled at the start and held for the whole session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | [15:0] repeat interval, [31:16] pause quantity |
| full_duplex | input | 1 | 1 selects PAUSE requests, 0 selects backpressure |
| fc_enable | input | 1 | Flow-control enable; rising edge starts a session |
| tick | input | 1 | Counter advance qualifier |
| pause_valid | output | 1 | PAUSE request offered to the transmitter |
| pause_ready | input | 1 | Transmitter takes the request |
| pause_time | output | 16 | Pause quantity for the requested frame |
| backpressure | output | 1 | Half-duplex backpressure level |
| status_word | output | 32 | Live counter value, upper half zero |

## Verification
The bench keeps the default 16-bit counter and 32-bit status width. It uses small field values (intervals of 0, 3 and 50, pause quantities of 0, 5 and 40), so every repeat gap and every backpressure window is measured cycle by cycle within a short run. With a zero interval and a zero quantity, the block's two degenerate paths are reached. Holding `pause_ready` low and dropping `tick` test the stall and hold rules. Flipping the duplex input in the middle of a session tests that the mode is latched at the start.

// File: rtl/fcpt_pkg.sv
package fcpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FD_REQ   = 3'd1,
    ST_FD_WAIT  = 3'd2,
    ST_FD_HOLD  = 3'd3,
    ST_FD_STOP  = 3'd4,
    ST_HD_PRESS = 3'd5
  } fc_state_e;

endpackage

// File: rtl/fcpt_enable_edge.sv
module fcpt_enable_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic level_q_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_i;
    end
  end

  assign rise_o    = level_i & ~level_q;
  assign level_q_o = level_q;

endmodule

// File: rtl/fcpt_mirror_counter.sv
module fcpt_mirror_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reached_o,
  output logic             below_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic             reached;

  assign reached = (count_q == limit_q);

  // The counter stops at the limit, so it can never wrap.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (run_i && tick_i && !reached) begin
      count_q <= count_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (load_i) begin
      limit_q <= limit_i;
    end
  end

  assign count_o   = count_q;
  assign reached_o = reached;
  assign below_o   = (count_q < limit_q);

endmodule

// File: rtl/fcpt_ctrl.sv
module fcpt_ctrl
  import fcpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             enable_i,
  input  logic             full_duplex_i,
  input  logic             accept_i,
  input  logic             reached_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [CNT_W-1:0] cfg_pause_i,
  output fc_state_e        state_o,
  output logic             clear_o,
  output logic             run_o,
  output logic             load_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             req_valid_o,
  output logic [CNT_W-1:0] req_time_o
);

  fc_state_e        state_q, state_d;
  logic [CNT_W-1:0] time_q, time_d;

  always_comb begin
    state_d = state_q;
    time_d  = time_q;
    clear_o = 1'b0;
    load_o  = 1'b0;
    limit_o = cfg_pause_i;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (full_duplex_i) begin
            state_d = ST_FD_REQ;
            time_d  = cfg_pause_i;
          end else if (cfg_pause_i != '0) begin
            state_d = ST_HD_PRESS;
            clear_o = 1'b1;
            load_o  = 1'b1;
            limit_o = cfg_pause_i;
          end
        end
      end
      ST_FD_REQ: begin
        if (accept_i) begin
          clear_o = 1'b1;
          if (!enable_i) begin
            state_d = ST_FD_STOP;
            time_d  = '0;
          end else if (cfg_period_i == '0) begin
            state_d = ST_FD_HOLD;
          end else begin
            state_d = ST_FD_WAIT;
            load_o  = 1'b1;
            limit_o = cfg_period_i;
          end
        end
      end
      ST_FD_WAIT: begin
        if (!enable_i) begin
          state_d = ST_FD_STOP;
          time_d  = '0;
        end else if (reached_i) begin
          state_d = ST_FD_REQ;
          time_d  = cfg_pause_i;
        end
      end
      ST_FD_HOLD: begin
        if (!enable_i) begin
          state_d = ST_FD_STOP;
          time_d  = '0;
        end
      end
      ST_FD_STOP: begin
        if (accept_i) begin
          state_d = ST_IDLE;
          clear_o = 1'b1;
        end
      end
      ST_HD_PRESS: begin
        if (!enable_i || reached_i) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      time_q  <= '0;
    end else begin
      state_q <= state_d;
      time_q  <= time_d;
    end
  end

  assign state_o     = state_q;
  assign run_o       = (state_q == ST_FD_WAIT) || (state_q == ST_HD_PRESS);
  assign req_valid_o = (state_q == ST_FD_REQ) || (state_q == ST_FD_STOP);
  assign req_time_o  = time_q;

endmodule

// File: rtl/flowctl_pause_timer.sv
module flowctl_pause_timer
  import fcpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*CNT_W-1:0]   cfg_word,
  input  logic                 full_duplex,
  input  logic                 fc_enable,
  input  logic                 tick,
  output logic                 pause_valid,
  input  logic                 pause_ready,
  output logic [CNT_W-1:0]     pause_time,
  output logic                 backpressure,
  output logic [STAT_W-1:0]    status_word
);

  localparam int CFG_W = 2 * CNT_W;

  logic [CNT_W-1:0] cfg_period;
  logic [CNT_W-1:0] cfg_pause;
  logic             start;
  logic             en_q;
  logic             accept;
  logic             clear;
  logic             run;
  logic             load;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;
  logic             reached;
  logic             below;
  fc_state_e        state;

  assign cfg_period = cfg_word[CNT_W-1:0];
  assign cfg_pause  = cfg_word[CFG_W-1:CNT_W];
  assign accept     = pause_valid & pause_ready;

  fcpt_enable_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (fc_enable),
    .rise_o    (start),
    .level_q_o (en_q)
  );

  fcpt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .enable_i      (fc_enable),
    .full_duplex_i (full_duplex),
    .accept_i      (accept),
    .reached_i     (reached),
    .cfg_period_i  (cfg_period),
    .cfg_pause_i   (cfg_pause),
    .state_o       (state),
    .clear_o       (clear),
    .run_o         (run),
    .load_o        (load),
    .limit_o       (limit),
    .req_valid_o   (pause_valid),
    .req_time_o    (pause_time)
  );

  fcpt_mirror_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .run_i     (run),
    .tick_i    (tick),
    .load_i    (load),
    .limit_i   (limit),
    .count_o   (count),
    .reached_o (reached),
    .below_o   (below)
  );

  assign backpressure = (state == ST_HD_PRESS) && below;

  generate
    if (STAT_W > CNT_W) begin : g_stat_pad
      assign status_word = {{(STAT_W-CNT_W){1'b0}}, count};
    end else begin : g_stat_cut
      assign status_word = count[STAT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/fcpt_checker.sv
module fcpt_checker #(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fc_enable,
  input logic              en_q,
  input logic              tick,
  input logic              pause_valid,
  input logic              pause_ready,
  input logic [CNT_W-1:0]  pause_time,
  input logic              backpressure,
  input logic [STAT_W-1:0] status_word
);

  logic [CNT_W-1:0] cnt_v;
  assign cnt_v = status_word[CNT_W-1:0];

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid && !pause_ready) |=> pause_valid); // R3
  AST_TIME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid && !pause_ready) |=> $stable(pause_time)); // R3
  AST_NO_BP_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(backpressure && pause_valid)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(pause_valid && pause_ready) && !(fc_enable && !en_q))
      |=> $stable(cnt_v)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_v == $past(cnt_v)) || (cnt_v == '0) ||
             (cnt_v == $past(cnt_v) + {{(CNT_W-1){1'b0}}, 1'b1})); // R4
  generate
    if (STAT_W > CNT_W) begin : g_upper
      AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[STAT_W-1:CNT_W] == '0); // R11
    end
  endgenerate

endmodule

bind flowctl_pause_timer fcpt_checker #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_fcpt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .fc_enable    (fc_enable),
  .en_q         (en_q),
  .tick         (tick),
  .pause_valid  (pause_valid),
  .pause_ready  (pause_ready),
  .pause_time   (pause_time),
  .backpressure (backpressure),
  .status_word  (status_word)
);

// File: tb/test_flowctl_pause_timer.sv
module test_flowctl_pause_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        full_duplex = 1'b0;
  logic        fc_enable = 1'b0;
  logic        tick = 1'b0;
  logic        pause_ready = 1'b0;
  logic        pause_valid;
  logic [15:0] pause_time;
  logic        backpressure;
  logic [31:0] status_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flowctl_pause_timer i_flowctl_pause_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word     (cfg_word),
    .full_duplex  (full_duplex),
    .fc_enable    (fc_enable),
    .tick         (tick),
    .pause_valid  (pause_valid),
    .pause_ready  (pause_ready),
    .pause_time   (pause_time),
    .backpressure (backpressure),
    .status_word  (status_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take();
    pause_ready = 1'b1;
    step(1);
    pause_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 32'(pause_valid), 0);
    chk("R1 bp in reset", 32'(backpressure), 0);
    step(1);
    rst_n = 1'b1;
    step(1);
    chk("R1 status after reset", status_word, 0);
    chk("R1 valid after reset", 32'(pause_valid), 0);
  endtask

  task automatic t_fd_period();
    int n;
    cfg_word = {16'h1234, 16'd3};
    full_duplex = 1'b1;
    tick = 1'b1;
    fc_enable = 1'b1;
    step(1);
    chk("R2 valid raised", 32'(pause_valid), 1);
    chk("R2 pause time", 32'(pause_time), 32'h1234);
    cfg_word = {16'h5555, 16'd3};
    step(3);
    chk("R3 valid held under stall", 32'(pause_valid), 1);
    chk("R3 time stable under stall", 32'(pause_time), 32'h1234);
    cfg_word = {16'h1234, 16'd3};
    take();
    n = 0;
    while (!pause_valid && n < 100) begin
      chk("R4 status follows count", status_word, 32'(n));
      n++;
      step(1);
    end
    chk("R4 reissue gap", 32'(n), 4);
    chk("R4 reissue time", 32'(pause_time), 32'h1234);
    pause_ready = 1'b1;
    step(1);
    pause_ready = 1'b0;
    tick = 1'b0;
    step(10);
    chk("R5 no request without tick", 32'(pause_valid), 0);
    chk("R5 count holds without tick", status_word, 0);
    tick = 1'b1;
    n = 0;
    while (!pause_valid && n < 100) begin
      n++;
      step(1);
    end
    chk("R4 gap after tick resumes", 32'(n), 4);
    fc_enable = 1'b0;
    step(1);
    chk("R7 pending request kept", 32'(pause_time), 32'h1234);
    take();
    chk("R7 final request valid", 32'(pause_valid), 1);
    chk("R7 final request zero", 32'(pause_time), 0);
    take();
    n = 0;
    repeat (20) begin
      if (pause_valid) n++;
      step(1);
    end
    chk("R7 quiet after final", 32'(n), 0);
    chk("R11 upper status zero", 32'(status_word[31:16]), 0);
  endtask

  task automatic t_fd_wait_stop();
    int n;
    cfg_word = {16'h00AB, 16'd50};
    full_duplex = 1'b1;
    tick = 1'b1;
    fc_enable = 1'b1;
    step(1);
    chk("R2 second start time", 32'(pause_time), 32'hAB);
    take();
    full_duplex = 1'b0;
    step(5);
    chk("R12 mode latched no bp", 32'(backpressure), 0);
    chk("R11 live count", status_word, 5);
    fc_enable = 1'b0;
    step(1);
    chk("R7 stop request valid", 32'(pause_valid), 1);
    chk("R7 stop request zero", 32'(pause_time), 0);
    take();
    n = 0;
    repeat (20) begin
      if (pause_valid) n++;
      step(1);
    end
    chk("R7 no request after stop", 32'(n), 0);
    full_duplex = 1'b1;
  endtask

  task automatic t_fd_once();
    int n;
    cfg_word = {16'h0777, 16'd0};
    full_duplex = 1'b1;
    tick = 1'b1;
    fc_enable = 1'b1;
    step(1);
    chk("R6 first request", 32'(pause_time), 32'h777);
    take();
    n = 0;
    repeat (30) begin
      if (pause_valid) n++;
      step(1);
    end
    chk("R6 never reissued", 32'(n), 0);
    fc_enable = 1'b0;
    step(1);
    chk("R7 stop after single", 32'(pause_valid), 1);
    chk("R7 stop time after single", 32'(pause_time), 0);
    take();
  endtask

  task automatic t_hd();
    int n;
    int v;
    cfg_word = {16'd5, 16'd99};
    full_duplex = 1'b0;
    tick = 1'b1;
    fc_enable = 1'b1;
    step(1);
    n = 0;
    v = 0;
    while (backpressure && n < 100) begin
      if (pause_valid) v++;
      n++;
      step(1);
    end
    chk("R8 backpressure length", 32'(n), 5);
    chk("R8 no request in half duplex", 32'(v), 0);
    chk("R11 status at end", status_word, 5);
    n = 0;
    repeat (10) begin
      if (backpressure) n++;
      step(1);
    end
    chk("R12 held level restarts nothing", 32'(n), 0);
    fc_enable = 1'b0;
    step(1);
  endtask

  task automatic t_hd_zero();
    int n;
    cfg_word = {16'd0, 16'd7};
    full_duplex = 1'b0;
    fc_enable = 1'b1;
    n = 0;
    repeat (10) begin
      step(1);
      if (backpressure) n++;
    end
    chk("R9 zero quantity no bp", 32'(n), 0);
    fc_enable = 1'b0;
    step(1);
  endtask

  task automatic t_hd_abort();
    cfg_word = {16'd40, 16'd0};
    full_duplex = 1'b0;
    tick = 1'b1;
    fc_enable = 1'b1;
    step(3);
    chk("R8 bp active", 32'(backpressure), 1);
    fc_enable = 1'b0;
    step(1);
    chk("R10 bp drops on disable", 32'(backpressure), 0);
  endtask

  initial begin
    step(2);
    t_reset();
    t_fd_period();
    t_fd_wait_stop();
    t_fd_once();
    t_hd();
    t_hd_zero();
    t_hd_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule